// File: doc/BRIEF.md
# Tile-Map Character Video Generator

This block turns raster position counts into a one-bit pixel stream. The screen is a 32 x 32 grid of cells, each 8 elements wide and 8 lines high. A tile RAM holds one byte code for each cell. Each code, together with the low three bits of the line count, selects one row of an 8 x 8 glyph in a glyph RAM. That row is loaded into a shift register and leaves it one pixel per element clock, leftmost pixel first. The output is forced low whenever the blank input is high. The element and line counts come from an external timing generator. The element count advances by one on every clock and keeps counting through horizontal blanking.

Both memories are single-ported RAMs that a CPU can write and read, so glyphs and the tile map can be changed at run time. The raster fetch owns the tile RAM at cell phase 5 and the glyph RAM at cell phase 6 (the phase is element count bits 2:0). A small arbiter state machine grants the CPU one access at a time, in slots that never collide with those fetches. It holds the CPU off until a slot arrives. The arbiter has three states. ARB_IDLE has no request pending. ARB_WAIT has a request waiting for a slot. ARB_CAPTURE is the cycle after a granted read, in which the read byte is latched. The transitions are: IDLE or WAIT to IDLE on a granted write; IDLE or WAIT to CAPTURE on a granted read; IDLE or WAIT to WAIT on a request without a slot; IDLE or WAIT to IDLE when there is no request; CAPTURE to IDLE always.

Top module: `tile_video_gen`

## Requirements
- R1: After reset, with no CPU request, `video`, `cpu_ack` and `cpu_rvalid` are all 0.
- R2: The tile code for a cell is read at tile RAM address {line_cnt[7:3], column}, where column is element count bits 7:3. The CPU reaches this as address row*32+column.
- R3: The glyph row is read at glyph RAM address {code, line_cnt[2:0]}, which is CPU address 0x800 + code*8 + row. Rewriting that location changes the pixels shown at the next fetch.
- R4: While blank is low and the element count is e, `video` equals bit 7-(e mod 8) of the glyph row for cell e/8. Bit 7 is the leftmost pixel. The fetch for a cell uses the tile and glyph contents and the line count present during the three elements before that cell.
- R5: `video` is 0 in every cycle in which `blank` is 1.
- R6: `cpu_ack` is asserted only when phase (element count bits 2:0) equals 2, or when `blank` is 1 and the phase is neither 5 nor 6.
- R7: A request held high with no slot available waits without effect. A write is performed in the cycle in which `cpu_ack` is high.
- R8: For a read acknowledged in cycle t, `cpu_rdata` carries the addressed byte and `cpu_rvalid` is high for exactly one cycle, in cycle t+2.
- R9: `cpu_addr[11]` selects the memory: 0 selects the tile RAM and 1 selects the glyph RAM. For tile accesses, `cpu_addr[10]` is ignored, so 0x400+n aliases n.
- R10: CPU reads made during active display do not alter any displayed pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Element clock |
| rst_n | input | 1 | Active-low synchronous reset |
| elem_cnt | input | 8 | Horizontal element count |
| line_cnt | input | 8 | Vertical line count |
| blank | input | 1 | High during retrace; forces video low |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | CPU address; bit 11 selects the glyph RAM |
| cpu_wdata | input | 8 | CPU write data |
| cpu_ack | output | 1 | Access performed at this clock edge |
| cpu_rdata | output | 8 | Read data |
| cpu_rvalid | output | 1 | One-cycle strobe marking valid read data |
| video | output | 1 | Serial pixel output |

## Verification
The tile and glyph contents are filled with position-dependent values, so a wrong address bit, a swapped row or column, or a reversed bit order changes specific pixels. Display runs span several character rows, so each line count bit 2:0 wrap must move to the next tile row. A second run follows a full glyph rewrite and tile changes, which separates run-time redefinition from stale data. CPU reads issued during active lines test the slot rule and confirm that the pixels stay intact. Writes through the aliased window and reads in blanking check the address decode.

// File: rtl/tvg_pkg.sv
package tvg_pkg;
    localparam int CELL_W = 3;
    localparam logic [CELL_W-1:0] PH_CPU  = 3'd2;
    localparam logic [CELL_W-1:0] PH_CODE = 3'd5;
    localparam logic [CELL_W-1:0] PH_PAT  = 3'd6;
    localparam logic [CELL_W-1:0] PH_LOAD = 3'd7;

    typedef enum logic [1:0] {
        ARB_IDLE,
        ARB_WAIT,
        ARB_CAPTURE
    } arb_state_t;
endpackage

// File: rtl/tvg_ram.sv
module tvg_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        q <= mem[addr];
    end
endmodule

// File: rtl/tvg_arbiter.sv
module tvg_arbiter
    import tvg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [CELL_W-1:0] phase,
    input  logic              blank,
    output logic              grant,
    output logic              capture
);
    arb_state_t state, state_nx;
    logic       slot_ok;

    assign slot_ok = (phase == PH_CPU) ||
                     (blank && (phase != PH_CODE) && (phase != PH_PAT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        grant    = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ARB_IDLE, ARB_WAIT: begin
                if (cpu_req && slot_ok) begin
                    grant    = 1'b1;
                    state_nx = cpu_we ? ARB_IDLE : ARB_CAPTURE;
                end else if (cpu_req) begin
                    state_nx = ARB_WAIT;
                end else begin
                    state_nx = ARB_IDLE;
                end
            end
            ARB_CAPTURE: begin
                capture  = 1'b1;
                state_nx = ARB_IDLE;
            end
            default: state_nx = ARB_IDLE;
        endcase
    end

    AST_CAPTURE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !cpu_we) |=> (state == ARB_CAPTURE)); // R8
endmodule

// File: rtl/tvg_shifter.sv
module tvg_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         msb
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= din;
        end else begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign msb = sr[W-1];
endmodule

// File: rtl/tile_video_gen.sv
module tile_video_gen
    import tvg_pkg::*;
#(
    parameter int ELEM_W = 8,
    parameter int LINE_W = 8,
    parameter int DATA_W = 8,
    parameter int CPU_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ELEM_W-1:0] elem_cnt,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic              blank,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              video
);
    localparam int COL_W  = ELEM_W - CELL_W;
    localparam int ROW_W  = LINE_W - CELL_W;
    localparam int SCR_AW = COL_W + ROW_W;
    localparam int PAT_AW = DATA_W + CELL_W;
    localparam int PIX_W  = 1 << CELL_W;

    logic [CELL_W-1:0] phase;
    logic [COL_W-1:0]  col_next;
    logic              grant, capture, pat_sel, rd_sel_q, load;
    logic              scr_cpu, pat_cpu;
    logic [SCR_AW-1:0] scr_addr;
    logic [PAT_AW-1:0] pat_addr;
    logic [DATA_W-1:0] scr_q, pat_q;

    assign phase    = elem_cnt[CELL_W-1:0];
    assign col_next = elem_cnt[ELEM_W-1:CELL_W] + COL_W'(1);
    assign pat_sel  = cpu_addr[CPU_AW-1];
    assign load     = (phase == PH_LOAD);

    tvg_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_req (cpu_req),
        .cpu_we  (cpu_we),
        .phase   (phase),
        .blank   (blank),
        .grant   (grant),
        .capture (capture)
    );

    assign scr_cpu  = grant && !pat_sel;
    assign pat_cpu  = grant && pat_sel;
    assign scr_addr = scr_cpu ? cpu_addr[SCR_AW-1:0]
                              : {line_cnt[LINE_W-1:CELL_W], col_next};
    assign pat_addr = pat_cpu ? cpu_addr[PAT_AW-1:0]
                              : {scr_q, line_cnt[CELL_W-1:0]};

    tvg_ram #(.AW(SCR_AW), .DW(DATA_W)) u_tile_ram (
        .clk   (clk),
        .we    (scr_cpu && cpu_we),
        .addr  (scr_addr),
        .wdata (cpu_wdata),
        .q     (scr_q)
    );

    tvg_ram #(.AW(PAT_AW), .DW(DATA_W)) u_glyph_ram (
        .clk   (clk),
        .we    (pat_cpu && cpu_we),
        .addr  (pat_addr),
        .wdata (cpu_wdata),
        .q     (pat_q)
    );

    logic pix;

    tvg_shifter #(.W(PIX_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (pat_q[PIX_W-1:0]),
        .msb   (pix)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel_q   <= 1'b0;
            cpu_rdata  <= '0;
            cpu_rvalid <= 1'b0;
        end else begin
            if (grant) begin
                rd_sel_q <= pat_sel;
            end
            if (capture) begin
                cpu_rdata <= rd_sel_q ? pat_q : scr_q;
            end
            cpu_rvalid <= capture;
        end
    end

    assign cpu_ack = grant;
    assign video   = pix && !blank;

    AST_SLOT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> ((phase == 3'd2) || (blank && phase != 3'd5 && phase != 3'd6))); // R6
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !cpu_we) |=> ##1 cpu_rvalid); // R8
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid); // R8
    AST_LOAD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && $past(load)) |-> (video == $past(pat_q[PIX_W-1]))); // R4
endmodule

// File: tb/tile_video_gen_tb.sv
module tile_video_gen_tb;
    typedef struct packed {
        logic       v;
        logic [3:0] req;
    } pix_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] elem_cnt, line_cnt;
    logic       blank;
    logic       cpu_req, cpu_we;
    logic [11:0] cpu_addr;
    logic [7:0] cpu_wdata;
    logic       cpu_ack, cpu_rvalid, video;
    logic [7:0] cpu_rdata;

    logic [7:0] scr_m [0:1023];
    logic [7:0] pat_m [0:2047];
    pix_t       pix_q [$];
    logic [7:0] rd_q  [$];

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  run_timing = 0;
    bit  want_disp  = 0;
    bit  disp_en    = 0;
    bit  force_blank = 1;
    bit  done = 0;
    int  lines_done = 0;
    logic [7:0] cur_line = 8'd0;

    always #10 clk = ~clk;

    tile_video_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .elem_cnt   (elem_cnt),
        .line_cnt   (line_cnt),
        .blank      (blank),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ack    (cpu_ack),
        .cpu_rdata  (cpu_rdata),
        .cpu_rvalid (cpu_rvalid),
        .video      (video)
    );

    function automatic logic exp_pix(input logic [7:0] ln, input logic [7:0] e);
        logic [7:0] code;
        code = scr_m[{ln[7:3], e[7:3]}];
        return pat_m[{code, ln[2:0]}][7 - e[2:0]];
    endfunction

    // timing driver: pushes the expected pixel of every displayed cycle
    initial begin
        wait (run_timing);
        forever begin
            disp_en     = want_disp;
            force_blank = !want_disp;
            cur_line    = cur_line + 8'd1;
            for (int e = 192; e < 256; e++) begin
                @(negedge clk);
                elem_cnt = 8'(e);
                line_cnt = cur_line;
                blank    = 1'b1;
                if (disp_en) pix_q.push_back('{v: 1'b0, req: 4'd5}); // R5
            end
            for (int e = 0; e < 256; e++) begin
                @(negedge clk);
                elem_cnt = 8'(e);
                blank    = force_blank;
                if (disp_en) begin
                    if (force_blank) pix_q.push_back('{v: 1'b0, req: 4'd5});
                    else pix_q.push_back('{v: exp_pix(cur_line, 8'(e)), req: 4'd4}); // R2 R3 R4 R10
                end
            end
            lines_done++;
        end
    end

    // monitor: pops and compares
    always @(negedge clk) begin
        #5;
        if (pix_q.size() > 0) begin
            pix_t it;
            it = pix_q.pop_front();
            n_cmp++;
            if (video !== it.v) begin
                n_bad++;
                $display("FAIL R%0d pixel (R2/R3 addressing, R10) line=%0d elem=%0d got=%b exp=%b",
                         it.req, line_cnt, elem_cnt, video, it.v);
            end
        end
        if (cpu_rvalid) begin
            logic [7:0] ex;
            n_cmp++;
            if (rd_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected rvalid got=%0h exp=none", cpu_rdata);
            end else begin
                ex = rd_q.pop_front();
                if (cpu_rdata !== ex) begin
                    n_bad++;
                    $display("FAIL R8/R9 read data got=%0h exp=%0h", cpu_rdata, ex);
                end
            end
        end
    end

    task automatic cpu_access(input logic we, input logic [11:0] a,
                              input logic [7:0] d, input logic [7:0] exp_rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #5;
        while (!cpu_ack) begin
            @(negedge clk);
            #5;
        end
        n_cmp++;
        if (!(elem_cnt[2:0] == 3'd2 ||
              (blank && elem_cnt[2:0] != 3'd5 && elem_cnt[2:0] != 3'd6))) begin
            n_bad++;
            $display("FAIL R6 ack in phase got=%0d exp=slot (blank=%b)", elem_cnt[2:0], blank);
        end
        if (!we) rd_q.push_back(exp_rd);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic wait_lines(input int n);
        int start;
        start = lines_done;
        while (lines_done < start + n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; elem_cnt = '0; line_cnt = '0; blank = 1'b1;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #5;
        n_cmp += 3; // R1
        if (video !== 1'b0) begin n_bad++; $display("FAIL R1 video got=%b exp=0", video); end
        if (cpu_ack !== 1'b0) begin n_bad++; $display("FAIL R1 ack got=%b exp=0", cpu_ack); end
        if (cpu_rvalid !== 1'b0) begin n_bad++; $display("FAIL R1 rvalid got=%b exp=0", cpu_rvalid); end
        run_timing = 1;

        // fill tile map (R2) and glyphs (R3); upper quarter via the aliased window (R9)
        for (int i = 0; i < 1024; i++) begin
            scr_m[i] = 8'((i * 7 + (i >> 5) * 13 + 3));
            cpu_access(1'b1, (i >= 768) ? 12'(i + 1024) : 12'(i), scr_m[i], 8'h00);
        end
        for (int i = 0; i < 2048; i++) begin
            pat_m[i] = 8'((i * 37) ^ (i >> 3) ^ 8'h5A);
            cpu_access(1'b1, 12'(2048 + i), pat_m[i], 8'h00);
        end
        // R7/R9 read back in blanking
        cpu_access(1'b0, 12'd5,          8'h00, scr_m[5]);
        cpu_access(1'b0, 12'(1024 + 800), 8'h00, scr_m[800]);
        cpu_access(1'b0, 12'd800,        8'h00, scr_m[800]);
        cpu_access(1'b0, 12'(2048 + 1234), 8'h00, pat_m[1234]);

        // first display run with CPU reads during active lines (R10, R6)
        want_disp = 1;
        wait_lines(1);
        for (int k = 0; k < 40; k++) begin
            cpu_access(1'b0, 12'((k * 97) % 1024), 8'h00, scr_m[(k * 97) % 1024]);
            cpu_access(1'b0, 12'(2048 + (k * 211) % 2048), 8'h00, pat_m[(k * 211) % 2048]);
        end
        wait_lines(12);
        want_disp = 0;
        wait_lines(2);

        // redefine glyphs and some tiles at run time (R3, R7)
        for (int i = 0; i < 2048; i++) begin
            pat_m[i] = ~pat_m[i] ^ 8'(i >> 4);
            cpu_access(1'b1, 12'(2048 + i), pat_m[i], 8'h00);
        end
        for (int i = 0; i < 1024; i += 3) begin
            scr_m[i] = 8'(255 - i);
            cpu_access(1'b1, 12'(i), scr_m[i], 8'h00);
        end
        want_disp = 1;
        wait_lines(10);
        want_disp = 0;
        wait_lines(2);
        while (pix_q.size() > 0 || rd_q.size() > 0) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule